// File: doc/BRIEF.md
# Pipelined Zero-Turnaround Synchronous SRAM

This block models a synchronous static RAM with a two-edge pipeline on both the read and the write side. It registers every control, address and byte-lane input on the rising clock edge. Write data lags its address by the same number of enabled edges as read data does. A controller can therefore issue reads and writes in any mix, one per cycle, and never has to insert an idle cycle when it switches direction. The shared data bus is split into a write-data input, a read-data output and an output-enable flag.

Three select inputs gate access to the array. A load/advance input either starts a new access or continues a four-word burst. The burst address steps through its group of four in linear order or in interleaved order. An active-low clock enable stalls the whole pipeline. A sleep input empties the pipeline and silences the outputs. Each 9-bit lane of a word has its own active-low write mask.

Top module: `zt_sram`

## Requirements
- R1: After a read is accepted on an enabled edge, rdata carries the word of that address after the second enabled edge that follows, and rdata_oe is high from that edge until the next enabled edge.
- R2: The block is selected only when sel1_n=0, sel2=1 and sel3_n=0. A load cycle (adv_n=0) under any other combination starts no access, and rdata_oe stays low for its data slot.
- R3: A write (we_n=0) accepted on an enabled edge stores wdata as sampled on the second enabled edge that follows. Lane i covers wdata bits [9i+8:9i] and is written only when lane_n[i]=0, where lane_n is sampled with the address.
- R4: A write with every lane_n bit high leaves the array unchanged, and rdata_oe stays low for its data slot.
- R5: Reads and writes may alternate on consecutive cycles with no idle cycle. A read accepted after a write to the same address returns the newly written data.
- R6: An edge with cke_n=1 is ignored. No pipeline stage, burst counter, output or array word changes on it.
- R7: A cycle with adv_n=1 continues the burst. It repeats the operation of the last load cycle, and that operation is none if the last load was deselected. It keeps the address bits above bit 1 and advances a two-bit burst count that wraps after four.
- R8: With order_lin=1, the low two address bits of burst step n are (start+n) mod 4. With order_lin=0 they are start XOR n. Here start is the low two bits of the load address.
- R9: While sleep is high, rdata_oe is low and every pending access is dropped. After sleep falls, rdata_oe stays low until a new read reaches its data slot.
- R10: During and right after reset, rdata_oe is low and no access is pending.
- R11: rdata_oe is low in the data slots of writes and of deselected or idle cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset of the control pipeline |
| cke_n | input | 1 | Active-low clock enable; high stalls the edge |
| sel1_n | input | 1 | Active-low select |
| sel2 | input | 1 | Active-high select |
| sel3_n | input | 1 | Active-low select |
| adv_n | input | 1 | 0 = load a new access, 1 = continue the burst |
| we_n | input | 1 | 0 = write, 1 = read (on load cycles) |
| lane_n | input | LANES | Active-low per-lane write mask |
| addr | input | ADDR_W | Word address |
| order_lin | input | 1 | 1 = linear burst order, 0 = interleaved |
| sleep | input | 1 | Sleep request, allowed only while deselected |
| wdata | input | DATA_W | Write data, sampled two enabled edges after its address |
| rdata | output | DATA_W | Read data |
| rdata_oe | output | 1 | High while rdata carries valid read data |

## Verification
A fault in the control pipeline shows up within two enabled edges of the faulty cycle: rdata_oe rises in the wrong slot, or it fails to rise for a read. A fault in the burst counter or the write path leaves no immediate mark. It surfaces only when that word is read again, so the bench compares every cycle against a behavioural model and reads back collided addresses often. Stalls and sleep are placed inside bursts and next to pending reads, so that a stage that moves when it should hold shifts rdata_oe by one cycle at once.

// File: rtl/zt_sram.sv
module zt_sram #(
  parameter int DATA_W = 36,
  parameter int LANE_W = 9,
  parameter int ADDR_W = 8,
  localparam int LANES = DATA_W / LANE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cke_n,
  input  logic              sel1_n,
  input  logic              sel2,
  input  logic              sel3_n,
  input  logic              adv_n,
  input  logic              we_n,
  input  logic [LANES-1:0]  lane_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              order_lin,
  input  logic              sleep,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              rdata_oe
);
  localparam int DEPTH = 1 << ADDR_W;

  typedef enum logic [1:0] {OP_NONE = 2'd0, OP_RD = 2'd1, OP_WR = 2'd2} op_e;

  logic [DATA_W-1:0] mem [DEPTH];
  logic [DATA_W-1:0] rdata_q;
  logic              oe_q;

  op_e               burst_op, a_op, b_op;
  logic [ADDR_W-1:0] base, a_addr, b_addr;
  logic [1:0]        start, cnt, nxt_cnt, lo;
  logic [LANES-1:0]  a_lane, b_lane;

  wire selected = !sel1_n && sel2 && !sel3_n;
  wire go       = !cke_n && !sleep;

  assign nxt_cnt  = cnt + 2'd1;
  assign lo       = order_lin ? (start + nxt_cnt) : (start ^ nxt_cnt);
  assign rdata    = rdata_q;
  assign rdata_oe = oe_q && !sleep;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      burst_op <= OP_NONE;
      a_op     <= OP_NONE;
      b_op     <= OP_NONE;
      oe_q     <= 1'b0;
      cnt      <= 2'd0;
      start    <= 2'd0;
      base     <= '0;
    end else if (sleep) begin
      a_op <= OP_NONE;
      b_op <= OP_NONE;
      oe_q <= 1'b0;
    end else if (!cke_n) begin
      b_op   <= a_op;
      b_addr <= a_addr;
      b_lane <= a_lane;
      oe_q   <= (b_op == OP_RD);
      a_lane <= lane_n;
      if (!adv_n) begin
        cnt <= 2'd0;
        if (selected) begin
          burst_op <= we_n ? OP_RD : OP_WR;
          a_op     <= we_n ? OP_RD : OP_WR;
          base     <= addr;
          start    <= addr[1:0];
          a_addr   <= addr;
        end else begin
          burst_op <= OP_NONE;
          a_op     <= OP_NONE;
        end
      end else begin
        cnt    <= nxt_cnt;
        a_op   <= burst_op;
        a_addr <= {base[ADDR_W-1:2], lo};
      end
    end
  end

  always_ff @(posedge clk) begin
    if (go && b_op == OP_WR) begin
      for (int i = 0; i < LANES; i++) begin
        if (!b_lane[i]) mem[b_addr][i*LANE_W +: LANE_W] <= wdata[i*LANE_W +: LANE_W];
      end
    end
    if (go && b_op == OP_RD) rdata_q <= mem[b_addr];
  end

  assert_read_slot_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (go && b_op == OP_RD) |=> oe_q);

  assert_desel_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (go && !adv_n && !selected) |=> (a_op == OP_NONE && burst_op == OP_NONE));

  assert_write_no_oe_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (go && b_op == OP_WR) |=> !oe_q);

  assert_stall_freeze_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (cke_n && !sleep) |=> ($stable(a_op) && $stable(b_op) && $stable(oe_q) && $stable(cnt)));

  assert_burst_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (go && adv_n) |=> cnt == $past(cnt) + 2'd1);

  assert_burst_group_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (go && adv_n && burst_op != OP_NONE) |=> a_addr[ADDR_W-1:2] == base[ADDR_W-1:2]);

  assert_sleep_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    sleep |=> (!oe_q && a_op == OP_NONE && b_op == OP_NONE));
endmodule

// File: tb/zt_sram_tb.sv
module zt_sram_tb_top;
  localparam int DW = 36;
  localparam int LW = 9;
  localparam int AW = 8;
  localparam int NL = DW / LW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic d_cke_n = 1'b0, d_s1n = 1'b1, d_s2 = 1'b0, d_s3n = 1'b1;
  logic d_adv_n = 1'b0, d_we_n = 1'b1, d_lin = 1'b1, d_sleep = 1'b0;
  logic [NL-1:0] d_lane = '1;
  logic [AW-1:0] d_addr = '0;
  logic [DW-1:0] d_wdata = '0;
  logic [DW-1:0] rdata;
  logic          rdata_oe;

  always #4 clk = ~clk;

  zt_sram #(.DATA_W(DW), .LANE_W(LW), .ADDR_W(AW)) dut_i (
    .clk(clk), .rst_n(rst_n), .cke_n(d_cke_n), .sel1_n(d_s1n), .sel2(d_s2),
    .sel3_n(d_s3n), .adv_n(d_adv_n), .we_n(d_we_n), .lane_n(d_lane),
    .addr(d_addr), .order_lin(d_lin), .sleep(d_sleep), .wdata(d_wdata),
    .rdata(rdata), .rdata_oe(rdata_oe));

  typedef struct { int op; int addr; int lanes; } ent_t;
  ent_t q[$];
  logic [DW-1:0] ref_mem [1<<AW];
  logic [DW-1:0] exp_data = '0;
  bit  exp_oe = 0;
  int  bop = 0, bbase = 0, bstart = 0, bcnt = 0;
  int  checks = 0, errors = 0;
  string tag = "R10";
  bit done = 0;

  function automatic void clear_q();
    ent_t e;
    e.op = 0; e.addr = 0; e.lanes = 0;
    q.delete();
    q.push_back(e);
    q.push_back(e);
  endfunction

  // behavioural reference model
  always @(posedge clk) begin
    if (!rst_n) begin
      clear_q();
      exp_oe = 0;
      bop = 0; bcnt = 0;
    end else if (d_sleep) begin
      clear_q();
      exp_oe = 0;
    end else if (!d_cke_n) begin
      ent_t e, n;
      e = q.pop_front();
      if (e.op == 2) begin
        for (int i = 0; i < NL; i++)
          if (!e.lanes[i]) ref_mem[e.addr][i*LW +: LW] = d_wdata[i*LW +: LW];
      end
      exp_oe = (e.op == 1);
      if (e.op == 1) exp_data = ref_mem[e.addr];
      n.lanes = int'(d_lane);
      if (!d_adv_n) begin
        bcnt = 0;
        if (!d_s1n && d_s2 && !d_s3n) begin
          bop = d_we_n ? 1 : 2;
          bbase = int'(d_addr);
          bstart = int'(d_addr) % 4;
          n.op = bop; n.addr = bbase;
        end else begin
          bop = 0; n.op = 0; n.addr = 0;
        end
      end else begin
        int lo;
        bcnt = (bcnt + 1) % 4;
        lo = d_lin ? (bstart + bcnt) % 4 : (bstart ^ bcnt);
        n.op = bop;
        n.addr = (bbase & ~3) | lo;
      end
      q.push_back(n);
    end
  end

  // compare every clock, away from the edge
  always @(posedge clk) begin
    #2;
    if (!done) begin
      checks++;
      if (rdata_oe !== (exp_oe && !d_sleep)) begin
        errors++;
        $display("FAIL %s rdata_oe got %0b exp %0b at %0t", tag, rdata_oe, exp_oe && !d_sleep, $time);
      end
      if (exp_oe && !d_sleep) begin
        checks++;
        if (rdata !== exp_data) begin
          errors++;
          $display("FAIL %s rdata got %h exp %h at %0t", tag, rdata, exp_data, $time);
        end
      end
    end
  end

  task automatic drive(bit stall, bit sel, int desel_kind, bit cont, bit wr,
                       logic [NL-1:0] lanes, logic [AW-1:0] a);
    @(negedge clk);
    d_cke_n = stall;
    d_s1n = 1'b0; d_s2 = 1'b1; d_s3n = 1'b0;
    if (!sel) begin
      if (desel_kind == 0) d_s1n = 1'b1;
      else if (desel_kind == 1) d_s2 = 1'b0;
      else d_s3n = 1'b1;
    end
    d_adv_n = cont;
    d_we_n = !wr;
    d_lane = lanes;
    d_addr = a;
    d_wdata = {$urandom, $urandom};
  endtask

  task automatic rnd(int n, int p_stall, int p_desel, int p_cont, int p_wr, int p_abort);
    for (int k = 0; k < n; k++) begin
      logic [NL-1:0] ln;
      ln = ($urandom_range(99) < p_abort) ? '1 : NL'($urandom);
      drive($urandom_range(99) < p_stall, !($urandom_range(99) < p_desel),
            $urandom_range(2), $urandom_range(99) < p_cont,
            $urandom_range(99) < p_wr, ln, AW'($urandom_range(15)));
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    // R10: reset state
    tag = "R10";
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R3: fill every word with full-lane writes
    tag = "R3";
    for (int a = 0; a < (1 << AW); a++) drive(0, 1, 0, 0, 1, '0, AW'(a));
    rnd(150, 0, 0, 0, 50, 0);
    tag = "R1";  rnd(100, 0, 0, 0, 0, 0);
    tag = "R5";  rnd(200, 0, 0, 0, 50, 0);
    tag = "R6";  rnd(200, 40, 0, 40, 50, 0);
    tag = "R4";  rnd(150, 10, 0, 20, 60, 50);
    tag = "R2";  rnd(150, 10, 40, 10, 50, 0);
    tag = "R7";  rnd(200, 10, 20, 70, 50, 10);
    tag = "R8";  d_lin = 1'b1; rnd(200, 15, 0, 75, 50, 0);
    d_lin = 1'b0; rnd(200, 15, 0, 75, 50, 0);
    tag = "R11"; d_lin = 1'b1; rnd(300, 20, 20, 40, 50, 20);
    // R9: sleep entered only while deselected
    tag = "R9";
    for (int k = 0; k < 2; k++) begin
      rnd(4, 0, 0, 0, 0, 0);
      repeat (3) drive(0, 0, 1, 0, 0, '1, '0);
      @(negedge clk); d_sleep = 1'b1;
      repeat (4) drive($urandom_range(1), 0, 0, 0, 0, '1, '0);
      @(negedge clk); d_sleep = 1'b0;
      drive(0, 0, 2, 0, 0, '1, '0);
      rnd(20, 10, 10, 30, 50, 0);
    end
    repeat (4) drive(0, 0, 0, 0, 0, '1, '0);
    @(negedge clk);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule